// File: doc/BRIEF.md
# Single-cycle RISC subset core

This is a 32-bit processor core that finishes one whole instruction in every clock cycle. In that cycle it fetches the instruction, decodes it, reads registers, computes in the ALU, reads or writes data memory and writes a result back. All reads are combinational. The program counter, the register file and the data memory are the only state, and all three update together on the rising clock edge. The instruction set is a small subset: register-register add, subtract, and, or and signed set-less-than, plus load word, store word and branch-if-equal.

The core holds its own small instruction and data memory arrays. A loader port fills the instruction array. A second port writes the data array and also reads any data word back at any time. A third port reads any architectural register. The usual flow is to hold reset, load a program and its data, then release reset and let the core run. Afterwards the results are inspected through the read-back ports.

Top module: `sc_core`

## Requirements
- R1: `rst` is an active-high synchronous reset. While it is sampled high, the PC becomes 0 and no register or data-memory word is changed by the core. The loader ports still write while reset is held.
- R2: Every instruction that is not a taken branch advances the PC by exactly 4 per cycle. The instruction executed is the instruction-array word at index PC/4.
- R3: Instructions with opcode 0x00 (bits 31:26) are register-register. Their fields are rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, shamt in bits 10:6 and funct in bits 5:0. Funct 0x20 writes rs+rt to rd and funct 0x22 writes rs-rt to rd, both wrapping modulo 2^32.
- R4: Funct 0x24 writes the bitwise AND of rs and rt to rd. Funct 0x25 writes their bitwise OR.
- R5: Funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R6: Opcode 0x23 (load) writes the data word at byte address rs + sign-extended imm[15:0] into rt. An address that is not a multiple of 4, or that lies past the end of the data array, reads as 0.
- R7: Opcode 0x2B (store) writes rt to the data word at rs + sign-extended imm[15:0] on the clock edge. The new value is seen by the next instruction. A store writes no register. Misaligned or out-of-range stores are dropped.
- R8: Opcode 0x04 (branch) compares rs and rt. When they are equal, the next PC is PC+4+sign-extended imm×4, and negative offsets work. When they differ, the next PC is PC+4.
- R9: Register 0 always reads as 0, and writes to it are discarded.
- R10: Any other opcode, any other funct, and any opcode-0x00 word with nonzero shamt executes as a no-op. It writes no register and no memory, and the PC advances by 4.
- R11: A register written by one instruction holds its new value for the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| img_we | input | 1 | Write strobe for the instruction array |
| img_addr | input | IAW | Word index into the instruction array |
| img_data | input | 32 | Instruction word to store |
| dat_we | input | 1 | Write strobe for the data array loader port |
| dat_addr | input | DAW | Word index for loader writes and read-back |
| dat_wdata | input | 32 | Data word to store |
| dat_rdata | output | 32 | Data word currently held at `dat_addr` |
| reg_sel | input | 5 | Register number to read back |
| reg_val | output | 32 | Current value of register `reg_sel` |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction word being executed this cycle |

## Verification
A wrong next-PC choice appears on `pc_o` one clock after the faulty instruction. From then on, every PC in the trace is off, so the per-cycle comparison of `pc_o` catches a missed or wrongly taken branch at once. A bad ALU result, a wrong write-back register or a lost store does not show at the ports until a later read-back. Each such result is therefore routed into a distinct register or data word that is checked once the program reaches its self-loop. Corruption of register 0 or of the load base shows up as wrongly placed memory traffic in the same program, and no-op words are checked by confirming that the register they name keeps its old value.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN  = 32;
  localparam int RIDX  = 5;
  localparam int NREGS = 1 << RIDX;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    mem_rd;
    logic    use_imm;
    logic    dst_rd;
    logic    branch;
    logic    illegal;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc,
                                                  input logic [15:0] imm);
    return pc + XLEN'(4) + (sext16(imm) << 2);
  endfunction
endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctl,
  output logic [RIDX-1:0] rs,
  output logic [RIDX-1:0] rt,
  output logic [RIDX-1:0] wa,
  output logic [15:0]     imm
);
  logic [5:0]      op;
  logic [5:0]      funct;
  logic [4:0]      shamt;
  logic [RIDX-1:0] rd;

  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign shamt = instr[10:6];
  assign funct = instr[5:0];
  assign imm   = instr[15:0];

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    case (op)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        if (shamt != '0) begin
          ctl.illegal = 1'b1;
        end else begin
          ctl.reg_we = 1'b1;
          case (funct)
            FN_ADD:  ctl.alu_op = ALU_ADD;
            FN_SUB:  ctl.alu_op = ALU_SUB;
            FN_AND:  ctl.alu_op = ALU_AND;
            FN_OR:   ctl.alu_op = ALU_OR;
            FN_SLT:  ctl.alu_op = ALU_SLT;
            default: begin
              ctl.reg_we  = 1'b0;
              ctl.illegal = 1'b1;
            end
          endcase
        end
      end
      OPC_LW: begin
        ctl.reg_we  = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.use_imm = 1'b1;
      end
      OPC_SW: begin
        ctl.mem_we  = 1'b1;
        ctl.use_imm = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

  assign wa = ctl.dst_rd ? rd : rt;
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int NRD = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [W-1:0]    wd,
  input  logic [RIDX-1:0] ra [NRD],
  output logic [W-1:0]    rd [NRD]
);
  logic [W-1:0] cells [1:NREGS-1];

  always_ff @(posedge clk) begin
    if (we && wa != '0) cells[wa] <= wd;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = (ra[g] == '0) ? '0 : cells[ra[g]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            img_we,
  input  logic [IAW-1:0]  img_addr,
  input  logic [XLEN-1:0] img_data,
  input  logic            dat_we,
  input  logic [DAW-1:0]  dat_addr,
  input  logic [XLEN-1:0] dat_wdata,
  output logic [XLEN-1:0] dat_rdata,
  input  logic [RIDX-1:0] reg_sel,
  output logic [XLEN-1:0] reg_val,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] next_pc;

  // named internal events (observed by the bound checker)
  logic            fetch_ok;
  logic [XLEN-1:0] instr_w;
  logic            rf_we;
  logic [RIDX-1:0] rf_wa;
  logic            dm_we;
  logic            dm_ok;
  logic            br_taken;
  logic            dec_illegal;

  ctrl_t           ctl;
  logic [RIDX-1:0] rs, rt;
  logic [15:0]     imm;
  logic [RIDX-1:0] rf_ra [3];
  logic [XLEN-1:0] rf_rd [3];
  logic [XLEN-1:0] alu_b, alu_y, dm_rdata, wb_data;
  logic            alu_zero;
  logic [DAW-1:0]  dm_idx;

  // fetch: outside the array reads as all-zero (an illegal funct, so a no-op)
  assign fetch_ok = (pc_q[XLEN-1:IAW+2] == '0) && (pc_q[1:0] == 2'b00);
  assign instr_w  = fetch_ok ? imem[pc_q[IAW+1:2]] : '0;

  sc_decode u_dec (
    .instr (instr_w),
    .ctl   (ctl),
    .rs    (rs),
    .rt    (rt),
    .wa    (rf_wa),
    .imm   (imm)
  );
  assign dec_illegal = ctl.illegal;

  assign rf_ra[0] = rs;
  assign rf_ra[1] = rt;
  assign rf_ra[2] = reg_sel;

  sc_regfile #(.W(XLEN), .NRD(3)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (rf_wa),
    .wd  (wb_data),
    .ra  (rf_ra),
    .rd  (rf_rd)
  );

  assign alu_b = ctl.use_imm ? sext16(imm) : rf_rd[1];

  sc_alu u_alu (
    .op   (ctl.alu_op),
    .a    (rf_rd[0]),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data access: word aligned and inside the array, else ignored
  assign dm_ok    = (alu_y[XLEN-1:DAW+2] == '0) && (alu_y[1:0] == 2'b00);
  assign dm_idx   = alu_y[DAW+1:2];
  assign dm_rdata = dm_ok ? dmem[dm_idx] : '0;
  assign wb_data  = ctl.mem_rd ? dm_rdata : alu_y;

  assign rf_we    = ctl.reg_we && !rst && (rf_wa != '0);
  assign dm_we    = ctl.mem_we && !rst && dm_ok;
  assign br_taken = ctl.branch && alu_zero;
  assign next_pc  = br_taken ? branch_dest(pc_q, imm) : pc_q + XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (img_we) imem[img_addr] <= img_data;
  end

  always_ff @(posedge clk) begin
    if (dat_we)     dmem[dat_addr] <= dat_wdata;
    else if (dm_we) dmem[dm_idx]   <= rf_rd[1];
  end

  assign dat_rdata = dmem[dat_addr];
  assign reg_val   = rf_rd[2];
  assign pc_o      = pc_q;
  assign instr_o   = instr_w;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        rf_we,
  input logic [4:0]  rf_wa,
  input logic        dm_we,
  input logic        br_taken,
  input logic        dec_illegal
);
  // high once at least one non-reset edge has passed since reset
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    rst |-> (!rf_we && !dm_we));

  assert_pc_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == 32'd0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(br_taken)) |-> (pc == $past(pc) + 32'd4));

  assert_pc_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(br_taken)) |->
      (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wa != 5'd0));

  assert_illegal_nop_R10: assert property (@(posedge clk) disable iff (rst)
    dec_illegal |-> (!rf_we && !dm_we && !br_taken));

  assert_store_nowb_R7: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc_q),
  .instr       (instr_w),
  .rf_we       (rf_we),
  .rf_wa       (rf_wa),
  .dm_we       (dm_we),
  .br_taken    (br_taken),
  .dec_illegal (dec_illegal)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        img_we = 1'b0;
  logic [5:0]  img_addr = '0;
  logic [31:0] img_data = '0;
  logic        dat_we = 1'b0;
  logic [5:0]  dat_addr = '0;
  logic [31:0] dat_wdata = '0;
  logic [31:0] dat_rdata;
  logic [4:0]  reg_sel = '0;
  logic [31:0] reg_val;
  logic [31:0] pc_o;
  logic [31:0] instr_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sc_core #(.IMEM_WORDS(64), .DMEM_WORDS(64)) u0 (
    .clk, .rst, .img_we, .img_addr, .img_data, .dat_we, .dat_addr,
    .dat_wdata, .dat_rdata, .reg_sel, .reg_val, .pc_o, .instr_o
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction

  localparam int PROG_LEN = 21;
  localparam logic [31:0] HALT_PC = 32'd80;

  function automatic logic [31:0] prog_word(int k);
    case (k)
      0:  return enc_r(0, 0, 8, 0, 6'h24);     // r8 = 0
      1:  return enc_i(6'h23, 0, 1, 16'd0);    // r1 = a
      2:  return enc_i(6'h23, 0, 2, 16'd4);    // r2 = b
      3:  return enc_r(1, 2, 3, 0, 6'h20);     // add
      4:  return enc_r(1, 2, 4, 0, 6'h22);     // sub
      5:  return enc_r(1, 2, 5, 0, 6'h24);     // and
      6:  return enc_r(1, 2, 6, 0, 6'h25);     // or
      7:  return enc_r(1, 2, 7, 0, 6'h2A);     // slt
      8:  return enc_i(6'h2B, 0, 3, 16'd8);    // word 2 = a+b
      9:  return enc_i(6'h04, 1, 2, 16'd1);    // skip next when a==b
      10: return enc_r(1, 0, 8, 0, 6'h20);     // r8 = a
      11: return enc_r(1, 0, 10, 0, 6'h20);    // r10 = a
      12: return enc_r(1, 2, 0, 0, 6'h20);     // write to r0
      13: return enc_r(2, 2, 10, 0, 6'h00);    // unknown funct
      14: return enc_i(6'h08, 2, 10, 16'h1234);// unknown opcode
      15: return enc_r(2, 2, 10, 1, 6'h20);    // nonzero shamt
      16: return enc_i(6'h2B, 0, 4, 16'd12);   // word 3 = a-b
      17: return enc_i(6'h23, 0, 13, 16'd16);  // r13 = 16
      18: return enc_i(6'h23, 13, 12, 16'hFFFC); // r12 = word 3
      19: return enc_i(6'h23, 0, 14, 16'd1);   // misaligned -> 0
      default: return enc_i(6'h04, 0, 0, 16'hFFFF); // self loop
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_check(string req, int r, logic [31:0] exp);
    reg_sel = 5'(r);
    #1;
    check(req, reg_val, exp);
  endtask

  task automatic mem_check(string req, int w, logic [31:0] exp);
    dat_addr = 6'(w);
    #1;
    check(req, dat_rdata, exp);
  endtask

  task automatic dat_load(int w, logic [31:0] v);
    dat_we = 1'b1; dat_addr = 6'(w); dat_wdata = v;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic run_vec(logic [31:0] a, logic [31:0] b);
    logic [31:0] exp_pc;
    logic [31:0] exp_r8;
    exp_r8 = (a == b) ? 32'd0 : a;
    rst = 1'b1;
    dat_load(0, a);
    dat_load(1, b);
    dat_load(4, 32'd16);
    @(negedge clk);
    check("R1 pc in reset", pc_o, 32'd0);
    rst = 1'b0;
    exp_pc = 32'd0;
    for (int c = 0; c < 26; c++) begin
      check((exp_pc == 32'd40 || exp_pc == 32'd44) ? "R8 pc" : "R2 pc", pc_o, exp_pc);
      if (exp_pc == 32'd36 && a == b) exp_pc = 32'd44;
      else if (exp_pc != HALT_PC)     exp_pc = exp_pc + 32'd4;
      @(negedge clk);
    end
    check("R8 self loop", pc_o, HALT_PC);
    reg_check("R6 load r1", 1, a);
    reg_check("R6 load r2", 2, b);
    reg_check("R3 add", 3, a + b);
    reg_check("R3 sub", 4, a - b);
    reg_check("R4 and", 5, a & b);
    reg_check("R4 or", 6, a | b);
    reg_check("R5 slt", 7, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
    reg_check("R8 skip", 8, exp_r8);
    reg_check("R10 noop keeps r10", 10, a);
    reg_check("R7 store then load", 12, a - b);
    reg_check("R11 base r13", 13, 32'd16);
    reg_check("R6 misaligned", 14, 32'd0);
    reg_check("R9 r0", 0, 32'd0);
    mem_check("R7 word2", 2, a + b);
    mem_check("R7 word3", 3, a - b);
    mem_check("R7 word4 kept", 4, 32'd16);
    // reset must stop the core from executing word 0 (which clears r8)
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 pc cleared", pc_o, 32'd0);
    if (exp_r8 != 32'd0) reg_check("R1 no write in reset", 8, exp_r8);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    logic [31:0] corner [8];
    logic [31:0] s;
    logic [31:0] va;
    corner = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
               32'h8000_0000, 32'h5555_5555, 32'hAAAA_AAAA, 32'h1234_5678};
    @(negedge clk);
    @(negedge clk);
    check("R1 pc after reset", pc_o, 32'd0);
    for (int k = 0; k < PROG_LEN; k++) begin
      img_we = 1'b1; img_addr = 6'(k); img_data = prog_word(k);
      @(negedge clk);
    end
    img_we = 1'b0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_vec(corner[i], corner[j]);
    s = 32'hC0FF_EE01;
    for (int n = 0; n < 16; n++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      va = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      run_vec(va, (n % 4 == 0) ? va : s);
    end
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end
endmodule